// File: doc/BRIEF.md
# One's-Complement Accumulator Core

This block is the arithmetic heart of a word-serial machine that stores 15-bit one's-complement numbers in memory, each with an odd-parity bit. It keeps a 16-bit accumulator. The extra top bit acts as the true sign and records when a result has run past the 15-bit range, so no separate flag is needed. Negative numbers are formed by inverting every bit, which means +0 (all zeros) and -0 (all ones) are separate values. The zero test accepts both of them as zero.

Each clock the core accepts one operation code and, for operations that read memory, one 16-bit memory word. The operations are load, add, complement, store-and-test, and no-op. On a store, the core presents the word to be written, with freshly generated parity. If the accumulator holds an overflow, the store also reloads the accumulator with a signed unit and raises a one-cycle skip request for the sequencer. A word read with bad parity raises a one-cycle error pulse and does not change the accumulator. Instruction decoding and addressing belong to the surrounding machine.

Top module: `acc1c_core`

## Requirements
- R1: While reset is asserted, and until the first operation after it, the accumulator reads 16'h0000, and skip, parity error and store-valid are all low.
- R2: Load (op code 1) copies data bits [14:0] of the memory word into the accumulator and copies bit 14 into accumulator bit 15. The new value is visible in the cycle after the op is presented.
- R3: Complement (op code 3) inverts all 16 accumulator bits.
- R4: Add (op code 2) sign-extends the operand to 16 bits and adds it to the accumulator. Any carry out of bit 15 is added back into bit 0. The result is overflowed when accumulator bits 15 and 14 differ.
- R5: Store (op code 4) on an overflowed accumulator does two things. It loads 16'h0001 when bit 15 is 0 and 16'hFFFE when bit 15 is 1, and it raises skip for exactly one cycle.
- R6: Store on an accumulator that is not overflowed leaves the accumulator unchanged and keeps skip low.
- R7: Every store raises store-valid for one cycle. The store word carries accumulator bit 15 in bit 14 and accumulator bits 13..0 in bits 13..0, taken before any reload. Bit 15 of the store word is set so that the whole 16-bit word has an odd number of ones.
- R8: Bit 15 of a memory word is its parity bit, and the word is valid when all 16 bits hold an odd count of ones. A load or add with even parity raises parity error for one cycle and leaves the accumulator unchanged.
- R9: The zero output is high exactly when the accumulator is 16'h0000 or 16'hFFFF.
- R10: Op code 0 and the unused codes 5 to 7 leave the accumulator unchanged and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_i | input | 3 | Operation code: 0 none, 1 load, 2 add, 3 complement, 4 store |
| mem_word_i | input | 16 | Memory read word: bit 15 parity, bits 14..0 data |
| acc_o | output | 16 | Accumulator contents |
| acc_zero_o | output | 1 | Accumulator is +0 or -0 |
| store_valid_o | output | 1 | One-cycle pulse, store word is valid |
| store_word_o | output | 16 | Word to write to memory, with odd parity in bit 15 |
| skip_o | output | 1 | One-cycle request to skip the next instruction |
| parity_err_o | output | 1 | One-cycle pulse, read word had even parity |

## Verification
A store on an overflowed accumulator does two jobs in the same cycle. It writes out the old accumulator, and it replaces that accumulator with a unit value and requests a skip. An error in either job could hide behind the other. The bench provokes this by driving the accumulator into positive and negative overflow with directed adds, and again in a long random mix of operations. On every clock, a behavioural integer model judges the store word, the new accumulator and the skip pulse against each other, so any mix-up between the pre-store and post-store values shows up as a mismatch.

// File: rtl/acc1c_pkg.sv
package acc1c_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_LOAD  = 3'd1,
    OP_ADD   = 3'd2,
    OP_COM   = 3'd3,
    OP_STORE = 3'd4
  } acc_op_e;
endpackage

// File: rtl/acc1c_xor_reduce.sv
module acc1c_xor_reduce #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] vec_i,
  output logic         odd_o
);
  logic [N-1:0] chain;

  assign chain[0] = vec_i[0];
  generate
    for (genvar i = 1; i < N; i++) begin : g_chain
      assign chain[i] = chain[i-1] ^ vec_i[i];
    end
  endgenerate
  assign odd_o = chain[N-1];
endmodule

// File: rtl/acc1c_adder.sv
module acc1c_adder #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  logic [W:0] raw;

  always_comb begin
    raw   = {1'b0, a_i} + {1'b0, b_i};
    sum_o = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
  end
endmodule

// File: rtl/acc1c_store_unit.sv
module acc1c_store_unit #(
  parameter int unsigned WORD_W = 15,
  localparam int unsigned ACC_W = WORD_W + 1
) (
  input  logic [ACC_W-1:0] acc_i,
  output logic             ovf_o,
  output logic [ACC_W-1:0] reload_o,
  output logic [WORD_W:0]  mem_word_o
);
  logic [WORD_W-1:0] payload;
  logic              payload_odd;

  assign ovf_o    = acc_i[ACC_W-1] ^ acc_i[ACC_W-2];
  assign reload_o = acc_i[ACC_W-1] ? {{(ACC_W-1){1'b1}}, 1'b0}
                                   : {{(ACC_W-1){1'b0}}, 1'b1};
  assign payload  = {acc_i[ACC_W-1], acc_i[ACC_W-3:0]};

  acc1c_xor_reduce #(.N(WORD_W)) u_pgen (
    .vec_i (payload),
    .odd_o (payload_odd)
  );

  assign mem_word_o = {~payload_odd, payload};
endmodule

// File: rtl/acc1c_core.sv
module acc1c_core #(
  parameter int unsigned WORD_W = 15,
  localparam int unsigned ACC_W = WORD_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_i,
  input  logic [WORD_W:0]   mem_word_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic              acc_zero_o,
  output logic              store_valid_o,
  output logic [WORD_W:0]   store_word_o,
  output logic              skip_o,
  output logic              parity_err_o
);
  import acc1c_pkg::*;

  logic [1:0]       rst_sync;
  logic             rst_ni;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic             acc_en;
  logic [WORD_W:0]  sw_q;
  logic             sw_en;
  logic             skip_q, skip_d;
  logic             perr_q, perr_d;
  logic             sv_q, sv_d;

  logic             rd_odd;
  logic             rd_ok;
  logic [ACC_W-1:0] operand;
  logic [ACC_W-1:0] sum;
  logic             ovf;
  logic [ACC_W-1:0] reload;
  logic [WORD_W:0]  st_word;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  acc1c_xor_reduce #(.N(WORD_W + 1)) u_pchk (
    .vec_i (mem_word_i),
    .odd_o (rd_odd)
  );
  assign rd_ok   = rd_odd;
  assign operand = {mem_word_i[WORD_W-1], mem_word_i[WORD_W-1:0]};

  acc1c_adder #(.W(ACC_W)) u_add (
    .a_i   (acc_q),
    .b_i   (operand),
    .sum_o (sum)
  );

  acc1c_store_unit #(.WORD_W(WORD_W)) u_store (
    .acc_i      (acc_q),
    .ovf_o      (ovf),
    .reload_o   (reload),
    .mem_word_o (st_word)
  );

  // next state
  always_comb begin
    acc_d  = acc_q;
    acc_en = 1'b0;
    sw_en  = 1'b0;
    skip_d = 1'b0;
    perr_d = 1'b0;
    sv_d   = 1'b0;
    case (op_i)
      OP_LOAD: begin
        if (rd_ok) begin
          acc_d  = operand;
          acc_en = 1'b1;
        end else begin
          perr_d = 1'b1;
        end
      end
      OP_ADD: begin
        if (rd_ok) begin
          acc_d  = sum;
          acc_en = 1'b1;
        end else begin
          perr_d = 1'b1;
        end
      end
      OP_COM: begin
        acc_d  = ~acc_q;
        acc_en = 1'b1;
      end
      OP_STORE: begin
        sv_d  = 1'b1;
        sw_en = 1'b1;
        if (ovf) begin
          acc_d  = reload;
          acc_en = 1'b1;
          skip_d = 1'b1;
        end
      end
      default: begin
        acc_d = acc_q;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      sw_q   <= '0;
      skip_q <= 1'b0;
      perr_q <= 1'b0;
      sv_q   <= 1'b0;
    end else begin
      if (acc_en) acc_q <= acc_d;
      if (sw_en)  sw_q  <= st_word;
      skip_q <= skip_d;
      perr_q <= perr_d;
      sv_q   <= sv_d;
    end
  end

  assign acc_o         = acc_q;
  assign acc_zero_o    = (acc_q == '0) || (acc_q == '1);
  assign store_valid_o = sv_q;
  assign store_word_o  = sw_q;
  assign skip_o        = skip_q;
  assign parity_err_o  = perr_q;

  // checks beside the logic they guard
  AST_OVF_RELOAD: assert property (@(posedge clk) disable iff (!rst_ni)
    (op_i == OP_STORE && acc_q[ACC_W-1] != acc_q[ACC_W-2])
      |=> (skip_o && (acc_o == {{(ACC_W-1){1'b0}}, 1'b1} ||
                      acc_o == {{(ACC_W-1){1'b1}}, 1'b0}))); // R5

  AST_STORE_KEEP: assert property (@(posedge clk) disable iff (!rst_ni)
    (op_i == OP_STORE && acc_q[ACC_W-1] == acc_q[ACC_W-2])
      |=> ($stable(acc_o) && !skip_o)); // R6

  AST_STORE_ODD: assert property (@(posedge clk) disable iff (!rst_ni)
    store_valid_o |-> ($countones(store_word_o) % 2 == 1)); // R7

  AST_PERR_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    ((op_i == OP_LOAD || op_i == OP_ADD) && ($countones(mem_word_i) % 2 == 0))
      |=> ($stable(acc_o) && parity_err_o)); // R8

  AST_COM_INV: assert property (@(posedge clk) disable iff (!rst_ni)
    (op_i == OP_COM) |=> (acc_o == ~$past(acc_o))); // R3

  AST_SKIP_CAUSE: assert property (@(posedge clk) disable iff (!rst_ni)
    skip_o |-> store_valid_o); // R5
endmodule

// File: tb/acc1c_core_test.sv
`timescale 1ns/1ps
module acc1c_core_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  op_i;
  logic [15:0] mem_word_i;
  logic [15:0] acc_o;
  logic        acc_zero_o, store_valid_o, skip_o, parity_err_o;
  logic [15:0] store_word_o;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  logic [15:0] m_acc;
  logic        e_skip, e_perr, e_sv;
  logic [15:0] e_sw;

  always #2.5 clk = ~clk;

  acc1c_core uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .mem_word_i(mem_word_i),
    .acc_o(acc_o), .acc_zero_o(acc_zero_o), .store_valid_o(store_valid_o),
    .store_word_o(store_word_o), .skip_o(skip_o), .parity_err_o(parity_err_o)
  );

  task automatic chk(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(logic [14:0] d, bit bad);
    bit p;
    p = ($countones(d) % 2 == 0);
    if (bad) p = ~p;
    return {p, d};
  endfunction

  task automatic compare_all(string tag);
    chk(tag, "acc", acc_o, m_acc);
    chk("R9", "zero", acc_zero_o, (m_acc == 16'h0000 || m_acc == 16'hFFFF));
    chk(e_skip ? "R5" : (tag == "R5" ? "R5" : "R6"), "skip", skip_o, e_skip);
    chk("R8", "perr", parity_err_o, e_perr);
    chk("R7", "store_valid", store_valid_o, e_sv);
    if (e_sv) chk("R7", "store_word", store_word_o, e_sw);
  endtask

  task automatic do_op(logic [2:0] op, logic [15:0] w, string tag);
    logic [15:0] pre, ext;
    logic [14:0] d15;
    int s;
    bit good;
    op_i = op;
    mem_word_i = w;
    pre  = m_acc;
    good = ($countones(w) % 2 == 1);
    ext  = w[14] ? {1'b1, w[14:0]} : {1'b0, w[14:0]};
    e_skip = 0; e_perr = 0; e_sv = 0;
    case (op)
      3'd1: if (good) m_acc = ext; else e_perr = 1;
      3'd2: if (good) begin
              s = int'(pre) + int'(ext);
              if (s > 65535) s = s - 65535;
              m_acc = s[15:0];
            end else e_perr = 1;
      3'd3: m_acc = ~pre;
      3'd4: begin
              e_sv = 1;
              d15  = {pre[15], pre[13:0]};
              e_sw = {($countones(d15) % 2 == 0), d15};
              if (pre[15] != pre[14]) begin
                e_skip = 1;
                m_acc  = pre[15] ? 16'hFFFE : 16'h0001;
              end
            end
      default: ;
    endcase
    @(negedge clk);
    compare_all(tag);
  endtask

  function automatic string tag_of(logic [2:0] op, logic [15:0] acc);
    case (op)
      3'd1: return "R2";
      3'd2: return "R4";
      3'd3: return "R3";
      3'd4: return (acc[15] != acc[14]) ? "R5" : "R6";
      default: return "R10";
    endcase
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    op_i = 3'd0;
    mem_word_i = 16'h0000;
    m_acc = 16'h0000;
    e_skip = 0; e_perr = 0; e_sv = 0; e_sw = 16'h0000;
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1;
    repeat (3) begin
      @(negedge clk);
      compare_all("R1");
    end

    do_op(3'd1, mk(15'd5, 0), "R2");
    do_op(3'd2, mk(15'd3, 0), "R4");
    do_op(3'd1, mk(15'h7FFD, 0), "R2");          // -2 extends to FFFD
    do_op(3'd2, mk(15'd5, 0), "R4");             // end-around gives 0003
    do_op(3'd4, 16'h0000, "R6");
    do_op(3'd1, mk(15'h3FFF, 0), "R2");
    do_op(3'd2, mk(15'd1, 0), "R4");             // positive overflow 4000
    do_op(3'd4, 16'h0000, "R5");                 // reload +1 and skip
    do_op(3'd4, 16'h0000, "R6");
    do_op(3'd1, mk(15'h4000, 0), "R2");
    do_op(3'd2, mk(15'h7FFE, 0), "R4");          // negative overflow BFFF
    do_op(3'd4, 16'h0000, "R5");                 // reload -1 and skip
    do_op(3'd1, mk(15'h0000, 0), "R9");
    do_op(3'd2, mk(15'h7FFF, 0), "R9");          // +0 plus -0 gives -0
    do_op(3'd3, 16'h0000, "R3");
    do_op(3'd1, mk(15'h1234, 1), "R8");
    do_op(3'd2, mk(15'h0001, 1), "R8");
    do_op(3'd5, mk(15'h0042, 0), "R10");
    do_op(3'd7, mk(15'h0042, 0), "R10");
    do_op(3'd0, mk(15'h0042, 0), "R10");
    do_op(3'd1, mk(15'h3000, 0), "R2");
    do_op(3'd2, mk(15'h3000, 0), "R4");
    do_op(3'd3, 16'h0000, "R3");                 // complement of overflow
    do_op(3'd4, 16'h0000, "R5");

    for (int i = 0; i < 2000; i++) begin
      logic [2:0]  op;
      logic [14:0] d;
      bit bad;
      op  = 3'($urandom % 8);
      if ($urandom % 3 == 0) op = 3'd2;
      d   = 15'($urandom);
      bad = ($urandom % 8 == 0);
      do_op(op, mk(d, bad), tag_of(op, m_acc));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule